// File: doc/BRIEF.md
# Trimmable Hysteresis Magnetic Switch Logic

This block turns a stream of signed field-strength samples into a two-state magnetic switch decision. Each sample is in gauss. Positive values mean a south field and negative values mean a north field, so a larger number is a stronger south field. The block compares each accepted sample against an operate threshold and a release threshold. The operate threshold is a signed untrimmed offset plus a 6-bit trim code times a fixed step. The release threshold sits a fixed hysteresis below the operate threshold, and that hysteresis is not programmable.

The decision drives a current-level select for a two-wire supply interface. With normal polarity, an operated switch draws low current. With reverse polarity, an operated switch draws high current. The first accepted sample after reset is judged against widened power-up limits: a field at least a guard margin above the operate threshold starts the switch operated, and every other field starts it released. After that first sample the ordinary hysteresis rules apply. The sensing front end and its filtering happen upstream of this block.

Top module: `magswitch_core`

## Requirements
- R1: While reset is high and after it, until the first accepted sample, `operated` is 0 and `hi_current` shows the released level: 1 for normal polarity, 0 for reverse polarity.
- R2: On the first sample accepted after reset, `operated` becomes 1 in the following cycle when the field is at least operate point + GUARD (default 10 G).
- R3: On the first accepted sample, any field below operate point + GUARD gives `operated` = 0. This covers a field at or below release point − GUARD and every field in the band between the two power-up limits.
- R4: When released, an accepted sample strictly above the operate point sets `operated` in the next cycle. A sample equal to the operate point leaves the switch released.
- R5: When operated, an accepted sample strictly below the release point clears `operated` in the next cycle. A sample equal to the release point leaves the switch operated.
- R6: An accepted sample that lies between the release point and the operate point, inclusive of both, keeps the present state.
- R7: The operate point is INIT_OFS + trim × STEP, with defaults −14 G and 5 G. The release point is the operate point − HYST, with a default of 15 G. At trim code 63 the operate point is 301 G and the arithmetic does not wrap.
- R8: A change of `trim_code` with no accepted sample leaves `operated` unchanged. The new code is applied at the next accepted sample.
- R9: With REVERSE = 0, `hi_current` is 0 whenever `operated` is 1 and 1 whenever `operated` is 0.
- R10: With REVERSE = 1, `hi_current` equals `operated`.
- R11: A field value presented while `sample_valid` is 0 has no effect on `operated`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; brings back power-up judgement |
| sample_valid | input | 1 | Marks `field_in` as a sample to accept this cycle |
| field_in | input | FIELD_W (16) | Signed field strength in gauss, positive = south |
| trim_code | input | TRIM_W (6) | Unsigned operate-point trim code |
| operated | output | 1 | 1 when the switch is in the operated state |
| hi_current | output | 1 | Current-level select, 1 = high current |

## Verification
The bench targets the exact threshold values: a sample equal to the operate point, one just above it, and the same pair at the release point. A design that used the wrong comparison there would switch one gauss early or late. The first sample is probed at the guard-band edges and inside the band; a design that applied ordinary hysteresis at power-up would come up operated inside the band. Trim code 63 and full-scale fields test the widened arithmetic, which a narrow datapath would wrap into a false release. Trim changes without a sample, and fields driven without the strobe, catch a design that reacts outside accepted samples. A reverse-polarity instance runs beside the normal one.

// File: rtl/magswitch_pkg.sv
package magswitch_pkg;

    typedef enum logic {
        SW_RELEASED = 1'b0,
        SW_OPERATED = 1'b1
    } sw_state_e;

    typedef struct packed {
        logic above_op;     // field strictly above operate point
        logic below_rp;     // field strictly below release point
        logic pwrup_on;     // field at or above operate point + guard
    } cmp_flags_t;

    function automatic sw_state_e next_state(
        input sw_state_e  cur,
        input logic       first,
        input cmp_flags_t fl
    );
        sw_state_e nxt;
        nxt = cur;
        if (first) begin
            nxt = fl.pwrup_on ? SW_OPERATED : SW_RELEASED;
        end else if (cur == SW_RELEASED && fl.above_op) begin
            nxt = SW_OPERATED;
        end else if (cur == SW_OPERATED && fl.below_rp) begin
            nxt = SW_RELEASED;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/magswitch_thresh.sv
module magswitch_thresh #(
    parameter int TRIM_W   = 6,
    parameter int CMP_W    = 26,
    parameter int INIT_OFS = -14,
    parameter int STEP     = 5,
    parameter int HYST     = 15,
    parameter int GUARD    = 10
) (
    input  logic [TRIM_W-1:0]       trim_code,
    output logic signed [CMP_W-1:0] op_pt,
    output logic signed [CMP_W-1:0] rel_pt,
    output logic signed [CMP_W-1:0] pwrup_pt
);
    logic signed [CMP_W-1:0] trim_x;
    logic signed [CMP_W-1:0] step_x;
    logic signed [CMP_W-1:0] ofs_x;

    always_comb begin
        trim_x   = CMP_W'(trim_code);
        step_x   = CMP_W'(STEP);
        ofs_x    = CMP_W'(INIT_OFS);
        op_pt    = ofs_x + trim_x * step_x;
        rel_pt   = op_pt - CMP_W'(HYST);
        pwrup_pt = op_pt + CMP_W'(GUARD);
    end
endmodule

// File: rtl/magswitch_cmp.sv
module magswitch_cmp
    import magswitch_pkg::*;
#(
    parameter int FIELD_W = 16,
    parameter int CMP_W   = 26
) (
    input  logic signed [FIELD_W-1:0] field_in,
    input  logic signed [CMP_W-1:0]   op_pt,
    input  logic signed [CMP_W-1:0]   rel_pt,
    input  logic signed [CMP_W-1:0]   pwrup_pt,
    output cmp_flags_t                flags
);
    logic signed [CMP_W-1:0] field_x;

    always_comb begin
        field_x        = CMP_W'(field_in);
        flags.above_op = (field_x > op_pt);
        flags.below_rp = (field_x < rel_pt);
        flags.pwrup_on = (field_x >= pwrup_pt);
    end
endmodule

// File: rtl/magswitch_state.sv
module magswitch_state
    import magswitch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sample_valid,
    input  cmp_flags_t flags,
    output sw_state_e  state
);
    logic primed;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SW_RELEASED;
            primed <= 1'b0;
        end else if (sample_valid) begin
            state  <= next_state(state, !primed, flags);
            primed <= 1'b1;
        end
    end
endmodule

// File: rtl/magswitch_core.sv
module magswitch_core
    import magswitch_pkg::*;
#(
    parameter int FIELD_W  = 16,
    parameter int TRIM_W   = 6,
    parameter int INIT_OFS = -14,
    parameter int STEP     = 5,
    parameter int HYST     = 15,
    parameter int GUARD    = 10,
    parameter bit REVERSE  = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sample_valid,
    input  logic signed [FIELD_W-1:0] field_in,
    input  logic [TRIM_W-1:0]         trim_code,
    output logic                      operated,
    output logic                      hi_current
);
    localparam int CMP_W = FIELD_W + TRIM_W + 4;

    logic signed [CMP_W-1:0] op_pt;
    logic signed [CMP_W-1:0] rel_pt;
    logic signed [CMP_W-1:0] pwrup_pt;
    cmp_flags_t              flags;
    sw_state_e               state;

    magswitch_thresh #(
        .TRIM_W(TRIM_W), .CMP_W(CMP_W), .INIT_OFS(INIT_OFS),
        .STEP(STEP), .HYST(HYST), .GUARD(GUARD)
    ) u_thresh (
        .trim_code(trim_code),
        .op_pt(op_pt),
        .rel_pt(rel_pt),
        .pwrup_pt(pwrup_pt)
    );

    magswitch_cmp #(
        .FIELD_W(FIELD_W), .CMP_W(CMP_W)
    ) u_cmp (
        .field_in(field_in),
        .op_pt(op_pt),
        .rel_pt(rel_pt),
        .pwrup_pt(pwrup_pt),
        .flags(flags)
    );

    magswitch_state u_state (
        .clk(clk),
        .rst(rst),
        .sample_valid(sample_valid),
        .flags(flags),
        .state(state)
    );

    assign operated = (state == SW_OPERATED);

    generate
        if (REVERSE) begin : g_rev
            assign hi_current = operated;
        end else begin : g_norm
            assign hi_current = !operated;
        end
    endgenerate
endmodule

// File: rtl/magswitch_props.sv
module magswitch_props #(
    parameter int FIELD_W  = 16,
    parameter int TRIM_W   = 6,
    parameter int INIT_OFS = -14,
    parameter int STEP     = 5,
    parameter int HYST     = 15,
    parameter int GUARD    = 10,
    parameter bit REVERSE  = 1'b0
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      sample_valid,
    input logic signed [FIELD_W-1:0] field_in,
    input logic [TRIM_W-1:0]         trim_code,
    input logic                      operated,
    input logic                      hi_current
);
    localparam int CW = FIELD_W + TRIM_W + 8;

    logic signed [CW-1:0] f_w;
    logic signed [CW-1:0] op_w;
    logic signed [CW-1:0] rp_w;
    logic signed [CW-1:0] up_w;
    logic                 seen;

    always_comb begin
        f_w  = CW'(field_in);
        op_w = CW'(INIT_OFS) + CW'(trim_code) * CW'(STEP);
        rp_w = op_w - CW'(HYST);
        up_w = op_w + CW'(GUARD);
    end

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else if (sample_valid) seen <= 1'b1;
    end

    assert_reset_released_R1: assert property (@(posedge clk)
        rst |=> !operated);

    assert_pwrup_on_R2: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && !seen && f_w >= up_w) |=> operated);

    assert_pwrup_off_R3: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && !seen && f_w < up_w) |=> !operated);

    assert_operate_R4: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && seen && !operated && f_w > op_w) |=> operated);

    assert_release_R5: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && seen && operated && f_w < rp_w) |=> !operated);

    assert_band_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && seen && f_w <= op_w && f_w >= rp_w) |=> $stable(operated));

    assert_trim_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!sample_valid && !$stable(trim_code)) |=> $stable(operated));

    assert_no_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> $stable(operated));

    assert_level_R9_R10: assert property (@(posedge clk) disable iff (rst)
        REVERSE ? (hi_current == operated) : (hi_current != operated));
endmodule

bind magswitch_core magswitch_props #(
    .FIELD_W(FIELD_W), .TRIM_W(TRIM_W), .INIT_OFS(INIT_OFS),
    .STEP(STEP), .HYST(HYST), .GUARD(GUARD), .REVERSE(REVERSE)
) u_props (
    .clk(clk), .rst(rst), .sample_valid(sample_valid),
    .field_in(field_in), .trim_code(trim_code),
    .operated(operated), .hi_current(hi_current)
);

// File: tb/magswitch_core_test.sv
module magswitch_core_test;
    logic               clk = 1'b0;
    logic               rst;
    logic               sample_valid;
    logic signed [15:0] field_in;
    logic [5:0]         trim_code;
    logic               op_n, hi_n, op_r, hi_r;

    int     checks = 0;
    int     errors = 0;
    int     cycles = 0;
    string  phase  = "R1";

    int m_state = 0;
    int m_seen  = 0;

    always #4 clk = ~clk;   // 125 MHz

    magswitch_core #(.REVERSE(1'b0)) uut (
        .clk(clk), .rst(rst), .sample_valid(sample_valid),
        .field_in(field_in), .trim_code(trim_code),
        .operated(op_n), .hi_current(hi_n)
    );

    magswitch_core #(.REVERSE(1'b1)) uut_rev (
        .clk(clk), .rst(rst), .sample_valid(sample_valid),
        .field_in(field_in), .trim_code(trim_code),
        .operated(op_r), .hi_current(hi_r)
    );

    task automatic check1(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", phase, what, act, exp);
        end
    endtask

    // One clock: drive, let the edge pass, update model, compare.
    task automatic step(input bit r, input bit v, input int f, input int t);
        int bop, brp;
        rst          = r;
        sample_valid = v;
        field_in     = 16'(f);
        trim_code    = 6'(t);
        @(posedge clk);
        bop = -14 + t * 5;
        brp = bop - 15;
        if (r) begin
            m_state = 0;
            m_seen  = 0;
        end else if (v) begin
            if (m_seen == 0) m_state = (f >= bop + 10) ? 1 : 0;
            else if (m_state == 0 && f > bop) m_state = 1;
            else if (m_state == 1 && f < brp) m_state = 0;
            m_seen = 1;
        end
        #2;
        check1("operated", int'(op_n), m_state);
        check1("hi_current normal (R9)", int'(hi_n), 1 - m_state);
        check1("operated reverse", int'(op_r), m_state);
        check1("hi_current reverse (R10)", int'(hi_r), m_state);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: actual=timeout expected=finished");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int lfsr;
        rst = 1'b1; sample_valid = 1'b0; field_in = '0; trim_code = '0;
        #2;
        phase = "R1";
        step(1, 0, 0, 0);
        step(1, 1, 30000, 0);
        step(0, 0, 0, 0);
        phase = "R11";
        step(0, 0, 30000, 0);
        step(0, 0, 1000, 0);
        // trim 0: op -14, rel -29, power-up on at -4, off at -39
        phase = "R3";
        step(0, 1, -5, 0);           // inside guard band -> released
        phase = "R4";
        step(0, 1, -14, 0);          // equal op -> stays released
        step(0, 1, -13, 0);          // above -> operated
        phase = "R11";
        step(0, 0, -30000, 0);
        phase = "R6";
        step(0, 1, -20, 0);
        step(0, 1, -29, 0);
        phase = "R5";
        step(0, 1, -30, 0);          // below release -> released
        phase = "R6";
        step(0, 1, -14, 0);
        // power-up operated at exactly the upper limit
        phase = "R2";
        step(1, 0, 0, 0);
        step(0, 1, -4, 0);
        phase = "R5";
        step(0, 1, -29, 0);
        step(0, 1, -30, 0);
        phase = "R3";
        step(1, 0, 0, 0);
        step(0, 1, -39, 0);
        step(1, 0, 0, 0);
        step(0, 1, -28, 0);          // band between power-up limits
        step(1, 0, 0, 0);
        step(0, 1, -5, 0);           // just under the upper limit
        // trim change without strobe
        phase = "R8";
        step(0, 1, 0, 0);            // operated at trim 0
        step(0, 0, 0, 63);
        step(0, 0, 0, 20);
        step(0, 1, 0, 63);           // op 301, rel 286 -> released
        // widest trim, full-scale fields
        phase = "R7";
        step(0, 1, 301, 63);
        step(0, 1, 302, 63);
        step(0, 1, 32767, 63);
        step(0, 1, 286, 63);
        step(0, 1, 285, 63);
        step(0, 1, -32768, 63);
        step(1, 0, 0, 0);
        step(0, 1, 311, 63);         // power-up on at 301+10
        step(1, 0, 0, 0);
        step(0, 1, 310, 63);
        phase = "R7";
        step(0, 1, 6, 4);            // op 6: equal, no switch
        step(0, 1, 7, 4);
        // mixed traffic against the model
        phase = "R6";
        lfsr = 32'h1ACE;
        for (int i = 0; i < 3000; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
            step((lfsr % 97) == 0, (lfsr & 3) != 0,
                 ((lfsr >> 2) % 420) - 60, (lfsr >> 9) % 64);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule